// File: doc/BRIEF.md
# Encoder count position extender

This block converts the reading of a free-running 16-bit quadrature up/down counter, which wraps around, into a 32-bit absolute shaft position. It also keeps the two positions before the current one, so that a control loop can form a velocity estimate across two sample periods. Across two periods the count difference is larger than across one, so a slowly turning shaft gives a less coarse velocity value.

The count arrives over an 8-bit path. A sample strobe opens a read. The next two byte transfers carry the high byte of the count and then the low byte. Once the low byte is in, the block takes the difference between the new count and the low 16 bits of the stored absolute position. It treats that difference as a signed 16-bit step, extends it to 32 bits and adds it to the stored position, so the counter's wraparound never appears as a jump. The history then moves down by one place. One registered update reports the new position, both older positions and the velocity difference together, marked by a one-cycle valid pulse.

Top module: `enc_pos_extender`

## Requirements
- R1: While reset is held and after it is released, all four 32-bit outputs read zero and `upd_vld` reads 0 until the first completed read.
- R2: A read is a `smp_stb` pulse followed by two accepted `byte_vld` transfers, the first being bits 15:8 of the count and the second bits 7:0. Idle cycles may occur between the transfers. The outputs change, with `upd_vld` high, exactly two clock edges after the edge that accepts the low byte.
- R3: A `smp_stb` pulse restarts the read. A high byte that was taken before the pulse is discarded, and a byte offered in the same cycle as the pulse is ignored.
- R4: A `byte_vld` transfer that arrives with no read open has no effect on any output. A read is open after `smp_stb` and before its low byte.
- R5: The first completed read after reset is the reference. `pos_cur`, `pos_prev1` and `pos_prev2` all take the count sign-extended to 32 bits, and `vel` is 0.
- R6: On each later read, the new `pos_cur` equals the old `pos_cur` plus the 16-bit difference (count minus old `pos_cur[15:0]`) read as a two's-complement value in -32768..32767. A difference of 0x8000 counts as -32768.
- R7: On each later read, `pos_prev2` takes the old `pos_prev1` and `pos_prev1` takes the old `pos_cur`.
- R8: On each update, `vel` equals the new `pos_cur` minus the new `pos_prev2`, modulo 2^32.
- R9: `upd_vld` is high for exactly one cycle per completed read. All four value outputs hold their values in every cycle in which `upd_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Sample strobe: opens a new counter read |
| byte_vld | input | 1 | A counter byte is present on `byte_dat` |
| byte_dat | input | 8 | Counter byte, high byte first |
| pos_cur | output | 32 | Absolute position x(n) |
| pos_prev1 | output | 32 | Position one update earlier, x(n-1) |
| pos_prev2 | output | 32 | Position two updates earlier, x(n-2) |
| vel | output | 32 | Signed difference x(n) - x(n-2) |
| upd_vld | output | 1 | One-cycle pulse marking a new update |

## Verification
The hardest case to reach is a step of exactly half the counter range. Only a difference of 0x8000 tells whether the signed interpretation puts that value on the negative side. The bench reaches it with an explicit read of 0x8005 right after a position ending in 0x0005, and then follows it with a step of +32767. It also checks the discarding of partial reads. To do so it strobes between a high byte and its low byte, and it offers a byte in the very cycle of a strobe, so that a stale high byte would show up in the next position.

// File: rtl/enc_ext_pkg.sv
package enc_ext_pkg;

    // Read sequencer mode of the byte assembler
    typedef enum logic [0:0] {
        ASM_IDLE  = 1'b0,
        ASM_ARMED = 1'b1
    } asm_mode_e;

endpackage

// File: rtl/enc_byte_asm.sv
module enc_byte_asm
    import enc_ext_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_stb,
    input  logic                       byte_vld,
    input  logic [BYTE_W-1:0]          byte_dat,
    output logic [NBYTES*BYTE_W-1:0]   word_o,
    output logic                       word_vld_o
);

    localparam int WORD_W = NBYTES * BYTE_W;
    localparam int HI_N   = NBYTES - 1;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        asm_mode_e                     mode;
        logic [IDX_W-1:0]              idx;
        logic [HI_N-1:0][BYTE_W-1:0]   slots;
        logic [WORD_W-1:0]             word;
        logic                          word_vld;
    } asm_st_t;

    asm_st_t st_d, st_q;
    logic [WORD_W-1:0] cat_word;

    // Held upper bytes sit most significant first; the current byte is the lowest
    genvar gi;
    generate
        for (gi = 0; gi < HI_N; gi++) begin : g_hi
            assign cat_word[WORD_W-1-gi*BYTE_W -: BYTE_W] = st_q.slots[gi];
        end
    endgenerate
    assign cat_word[BYTE_W-1:0] = byte_dat;

    always_comb begin
        st_d          = st_q;
        st_d.word_vld = 1'b0;
        if (smp_stb) begin
            st_d.mode = ASM_ARMED;
            st_d.idx  = '0;
        end else if (byte_vld && (st_q.mode == ASM_ARMED)) begin
            if (st_q.idx == IDX_W'(NBYTES - 1)) begin
                st_d.word     = cat_word;
                st_d.word_vld = 1'b1;
                st_d.mode     = ASM_IDLE;
                st_d.idx      = '0;
            end else begin
                for (int i = 0; i < HI_N; i++) begin
                    if (st_q.idx == IDX_W'(i)) begin
                        st_d.slots[i] = byte_dat;
                    end
                end
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o     = st_q.word;
    assign word_vld_o = st_q.word_vld;

endmodule

// File: rtl/enc_delta_ext.sv
module enc_delta_ext #(
    parameter int CNT_W = 16,
    parameter int POS_W = 32
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [POS_W-1:0] pos_prev_i,
    input  logic             ref_done_i,
    output logic [POS_W-1:0] pos_next_o
);

    localparam int EXT_W = POS_W - CNT_W;

    logic [CNT_W-1:0] step;
    logic [POS_W-1:0] step_ext;
    logic [POS_W-1:0] cnt_ext;

    always_comb begin
        step     = cnt_i - pos_prev_i[CNT_W-1:0];
        step_ext = {{EXT_W{step[CNT_W-1]}}, step};
        cnt_ext  = {{EXT_W{cnt_i[CNT_W-1]}}, cnt_i};
        if (ref_done_i) begin
            pos_next_o = pos_prev_i + step_ext;
        end else begin
            pos_next_o = cnt_ext;
        end
    end

endmodule

// File: rtl/enc_hist.sv
module enc_hist #(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [POS_W-1:0] pos_i,
    output logic [POS_W-1:0] cur_o,
    output logic [POS_W-1:0] prev1_o,
    output logic [POS_W-1:0] prev2_o,
    output logic [POS_W-1:0] vel_o,
    output logic             vld_o,
    output logic             ref_done_o
);

    typedef struct packed {
        logic [POS_W-1:0] cur;
        logic [POS_W-1:0] prev1;
        logic [POS_W-1:0] prev2;
        logic [POS_W-1:0] vel;
        logic             vld;
        logic             ref_done;
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (load_i) begin
            st_d.vld = 1'b1;
            if (!st_q.ref_done) begin
                st_d.cur      = pos_i;
                st_d.prev1    = pos_i;
                st_d.prev2    = pos_i;
                st_d.vel      = '0;
                st_d.ref_done = 1'b1;
            end else begin
                // Difference taken against the entry that becomes x(n-2)
                st_d.vel   = pos_i - st_q.prev1;
                st_d.prev2 = st_q.prev1;
                st_d.prev1 = st_q.cur;
                st_d.cur   = pos_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o      = st_q.cur;
    assign prev1_o    = st_q.prev1;
    assign prev2_o    = st_q.prev2;
    assign vel_o      = st_q.vel;
    assign vld_o      = st_q.vld;
    assign ref_done_o = st_q.ref_done;

endmodule

// File: rtl/enc_pos_extender.sv
module enc_pos_extender #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int POS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    output logic [POS_W-1:0]  pos_cur,
    output logic [POS_W-1:0]  pos_prev1,
    output logic [POS_W-1:0]  pos_prev2,
    output logic [POS_W-1:0]  vel,
    output logic              upd_vld
);

    localparam int NBYTES = CNT_W / BYTE_W;

    logic [CNT_W-1:0] cnt_word;
    logic             cnt_vld;
    logic [POS_W-1:0] pos_next;
    logic             ref_done;

    enc_byte_asm #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_stb    (smp_stb),
        .byte_vld   (byte_vld),
        .byte_dat   (byte_dat),
        .word_o     (cnt_word),
        .word_vld_o (cnt_vld)
    );

    enc_delta_ext #(
        .CNT_W (CNT_W),
        .POS_W (POS_W)
    ) u_delta (
        .cnt_i      (cnt_word),
        .pos_prev_i (pos_cur),
        .ref_done_i (ref_done),
        .pos_next_o (pos_next)
    );

    enc_hist #(
        .POS_W (POS_W)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_vld),
        .pos_i      (pos_next),
        .cur_o      (pos_cur),
        .prev1_o    (pos_prev1),
        .prev2_o    (pos_prev2),
        .vel_o      (vel),
        .vld_o      (upd_vld),
        .ref_done_o (ref_done)
    );

endmodule

// File: rtl/enc_pos_extender_chk.sv
module enc_pos_extender_chk #(
    parameter int CNT_W = 16,
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic             byte_vld,
    input logic [POS_W-1:0] pos_cur,
    input logic [POS_W-1:0] pos_prev1,
    input logic [POS_W-1:0] pos_prev2,
    input logic [POS_W-1:0] vel,
    input logic             upd_vld
);

    logic             seen_q;
    logic [POS_W-1:0] cur_hold_q;
    logic [POS_W-1:0] jump;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            cur_hold_q <= '0;
        end else begin
            if (upd_vld) seen_q <= 1'b1;
            cur_hold_q <= pos_cur;
        end
    end

    assign jump = pos_cur - cur_hold_q;

    // R2: an update follows a low byte accepted two edges earlier
    a_r2_low_byte_latency: assert property (@(posedge clk) disable iff (!rst_n)
        upd_vld |-> ($past(byte_vld, 2) && !$past(smp_stb, 2)));

    // R5: reference read fills the history with one value and no velocity
    a_r5_reference: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && !seen_q) |-> (pos_prev1 == pos_cur && pos_prev2 == pos_cur && vel == '0));

    // R6: each later step fits a signed counter-width value
    a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && seen_q) |-> (jump[POS_W-1:CNT_W-1] == '0 || jump[POS_W-1:CNT_W-1] == '1));

    // R7: history moves down by one place
    a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && seen_q) |-> (pos_prev1 == $past(pos_cur) && pos_prev2 == $past(pos_prev1)));

    // R8: velocity spans two updates
    a_r8_velocity: assert property (@(posedge clk) disable iff (!rst_n)
        upd_vld |-> (vel == pos_cur - pos_prev2));

    // R9: single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_vld |=> !upd_vld);

    // R9: values hold between updates
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_vld |-> ($stable(pos_cur) && $stable(pos_prev1) && $stable(pos_prev2) && $stable(vel)));

endmodule

bind enc_pos_extender enc_pos_extender_chk #(
    .CNT_W (CNT_W),
    .POS_W (POS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .byte_vld  (byte_vld),
    .pos_cur   (pos_cur),
    .pos_prev1 (pos_prev1),
    .pos_prev2 (pos_prev2),
    .vel       (vel),
    .upd_vld   (upd_vld)
);

// File: tb/enc_pos_extender_tb.sv
module enc_pos_extender_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_stb;
    logic        byte_vld;
    logic [7:0]  byte_dat;
    logic [31:0] pos_cur, pos_prev1, pos_prev2, vel;
    logic        upd_vld;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural model state
    bit          m_open = 1'b0;
    int          m_cnt  = 0;
    logic [7:0]  m_hi;
    logic [15:0] pend_q[$];
    bit          m_ref = 1'b0;
    logic [31:0] e_cur = '0, e_p1 = '0, e_p2 = '0, e_vel = '0;
    bit          e_upd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_pos_extender u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .byte_vld  (byte_vld),
        .byte_dat  (byte_dat),
        .pos_cur   (pos_cur),
        .pos_prev1 (pos_prev1),
        .pos_prev2 (pos_prev2),
        .vel       (vel),
        .upd_vld   (upd_vld)
    );

    task automatic check_val(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_apply(logic [15:0] w);
        int          dd;
        logic [31:0] nxt;
        if (!m_ref) begin
            nxt   = {{16{w[15]}}, w};
            e_cur = nxt; e_p1 = nxt; e_p2 = nxt; e_vel = '0;
            m_ref = 1'b1;
        end else begin
            dd = int'(w) - int'(e_cur[15:0]);
            if (dd > 32767)  dd -= 65536;
            if (dd < -32768) dd += 65536;
            nxt   = e_cur + 32'(dd);
            e_p2  = e_p1;
            e_p1  = e_cur;
            e_cur = nxt;
            e_vel = e_cur - e_p2;
        end
    endtask

    task automatic model_edge(bit s, bit v, logic [7:0] d);
        e_upd = 1'b0;
        if (pend_q.size() > 0) begin
            model_apply(pend_q.pop_front());
            e_upd = 1'b1;
        end
        if (s) begin
            m_open = 1'b1; m_cnt = 0;
        end else if (v && m_open) begin
            if (m_cnt == 0) begin
                m_hi = d; m_cnt = 1;
            end else begin
                pend_q.push_back({m_hi, d});
                m_open = 1'b0; m_cnt = 0;
            end
        end
    endtask

    task automatic compare_all();
        check_val(cur_req, "pos_cur",   pos_cur,   e_cur);
        check_val(cur_req, "pos_prev1", pos_prev1, e_p1);
        check_val(cur_req, "pos_prev2", pos_prev2, e_p2);
        check_val(cur_req, "vel",       vel,       e_vel);
        check_val(cur_req, "upd_vld",   {31'd0, upd_vld}, {31'd0, e_upd});
    endtask

    task automatic step(bit s, bit v, logic [7:0] d);
        smp_stb = s; byte_vld = v; byte_dat = d;
        @(posedge clk);
        model_edge(s, v, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic read_word(logic [15:0] w, int gap);
        step(1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b1, w[15:8]);
        for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, w[7:0]);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] cnt;
        rst_n = 1'b0; smp_stb = 1'b0; byte_vld = 1'b0; byte_dat = '0;
        repeat (3) @(negedge clk);
        // R1: zero state under reset
        check_val("R1", "pos_cur in reset", pos_cur, 32'h0);
        check_val("R1", "upd_vld in reset", {31'd0, upd_vld}, 32'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        check_val("R1", "vel after reset", vel, 32'h0);

        // R5: first read is the reference
        cur_req = "R5";
        read_word(16'hFFF0, 0);
        check_val("R5", "ref pos_cur", pos_cur, 32'hFFFF_FFF0);
        check_val("R5", "ref pos_prev2", pos_prev2, 32'hFFFF_FFF0);
        check_val("R5", "ref vel", vel, 32'h0);

        // R6: forward wrap of the counter
        cur_req = "R6";
        read_word(16'h0005, 0);
        check_val("R6", "wrap up pos_cur", pos_cur, 32'h0000_0005);
        check_val("R8", "wrap up vel", vel, 32'h0000_0015);
        check_val("R7", "wrap up pos_prev1", pos_prev1, 32'hFFFF_FFF0);

        // R6: half-range step counts as negative
        read_word(16'h8005, 1);
        check_val("R6", "half range pos_cur", pos_cur, 32'hFFFF_8005);
        read_word(16'h0004, 0);
        check_val("R6", "max positive step", pos_cur, 32'h0000_0004);
        check_val("R7", "prev1 after shift", pos_prev1, 32'hFFFF_8005);
        check_val("R7", "prev2 after shift", pos_prev2, 32'h0000_0005);
        check_val("R8", "vel two back", vel, 32'hFFFF_FFFF);

        // R3: strobe after a lone high byte restarts the read
        cur_req = "R3";
        step(1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b1, 8'hAA);
        step(1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h10);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        check_val("R3", "restart pos_cur", pos_cur, 32'h0000_0010);
        // R3: byte in the strobe cycle is ignored
        step(1'b1, 1'b1, 8'h55);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h20);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        check_val("R3", "strobe byte pos_cur", pos_cur, 32'h0000_0020);

        // R4: stray bytes with no open read
        cur_req = "R4";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'h12 + 8'(i));
        check_val("R4", "stray pos_cur", pos_cur, 32'h0000_0020);
        check_val("R4", "stray upd_vld", {31'd0, upd_vld}, 32'h0);

        // R2: gaps between bytes
        cur_req = "R2";
        read_word(16'h0123, 3);
        check_val("R2", "gapped pos_cur", pos_cur, 32'h0000_0123);

        // R9: long mixed run, model compared each clock
        cur_req = "R9";
        cnt = 16'h0123;
        for (int n = 0; n < 400; n++) begin
            int dlt;
            dlt = int'($urandom_range(0, 8000)) - 4000;
            if (n % 50 == 7) dlt = 32767;
            if (n % 50 == 21) dlt = -32768;
            cnt = cnt + 16'(dlt);
            read_word(cnt, int'($urandom_range(0, 2)));
            if (n % 9 == 4) step(1'b0, 1'b1, 8'hEE);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule